// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block arbitrates interrupts for a small 8-bit processor core. It serves three sources: an external interrupt pin, which is asynchronous and active on its falling edge, and two overflow pulses from timer/event counters. Each source owns a request flag and an enable bit. A single master enable sits above all of them. All of these bits live in one 8-bit control/status register that software reads and writes over a simple strobe-and-data port.

The core gives the block an instruction-cycle sampling pulse. On each such pulse the controller checks whether an enabled request is pending, the master enable is set and the return stack has room. When all of these hold, it picks the highest-priority source and gives the core a one-cycle call request with that source's fixed vector. On the same edge it clears that source's flag and drops the master enable. The core reports RET and RETI completions back to the block. Only RETI restores the master enable.

Requests that arrive between two sampling pulses stay latched and are considered at the next pulse. Masked or blocked requests are never lost.

Top module: `vpic_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the register reads 00H and the call request is low.
- R2: Register layout: bit 0 is the master enable, bits 1/2/3 enable external/timer 0/timer 1, bits 4/5/6 are the external/timer 0/timer 1 request flags, and bit 7 always reads 0. A write with reg_we_i loads bits 0 to 6 at the next edge.
- R3: A one-cycle timer overflow pulse sets its flag at the next edge. A falling edge on ext_irq_ni sets the external flag at the third rising edge after the pin is sampled low. A rising edge sets nothing.
- R4: An interrupt is taken at an edge where tick_i is high only when its flag, its enable and the master enable are all 1 and stack_full_i is 0.
- R5: When several sources qualify, the external source wins over timer 0, and timer 0 wins over timer 1.
- R6: A taken interrupt raises call_req_o for exactly one cycle, starting right after the tick edge. call_vec_o is 04H for external, 08H for timer 0 and 0CH for timer 1.
- R7: On the edge where an interrupt is taken, that source's flag and the master enable both clear. Clearing the master enable has priority over a coincident RETI or write.
- R8: reti_i sets the master enable at the next edge. ret_i alone leaves it unchanged.
- R9: Requests are never serviced at an edge without tick_i. A flag latched between ticks is serviced at the next tick.
- R10: A flag stays set while the source is masked, until it is serviced or written to 0. A hardware set in the same cycle as a software write of 0 leaves the flag set.
- R11: No interrupt is taken while stack_full_i is high. The pending flag is kept and serviced at a later tick once the stack has room.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Instruction-cycle sampling pulse |
| ext_irq_ni | input | 1 | External interrupt pin, asynchronous, falling edge active |
| tmr0_ovf_i | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf_i | input | 1 | Timer 1 overflow pulse |
| stack_full_i | input | 1 | Return stack has no free entry |
| ret_i | input | 1 | Core completed a plain return |
| reti_i | input | 1 | Core completed a return-from-interrupt |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| call_req_o | output | 1 | One-cycle interrupt call request |
| call_vec_o | output | 8 | Vector address of the call |

## Verification
Every state bit of this block is visible in the register image. A wrong flag, enable or master-enable value therefore shows up on reg_rdata_o on the very next cycle. A wrong arbitration or qualification decision shows up within one cycle as a missing call pulse, an extra call pulse or the wrong vector. The bench compares the register image, the call pulse and the vector against a behavioural model after every clock edge. This catches a fault within one cycle of its cause. Directed sequences cover the orderings the model alone would rarely meet: coincident requests, a RETI during a take, a set racing a write, and a stack that is full on a tick.

// File: rtl/vpic_pkg.sv
package vpic_pkg;

  localparam int unsigned NUM_SRC = 3;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned VEC_W   = 8;

  localparam int unsigned EN_LSB  = 1;
  localparam int unsigned FLG_LSB = EN_LSB + NUM_SRC;
  localparam int unsigned PAD_W   = REG_W - 1 - 2 * NUM_SRC;

  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_RET  = 2'd1,
    RK_RETI = 2'd2
  } ret_kind_e;

  typedef struct packed {
    logic [NUM_SRC-1:0] flg;
    logic [NUM_SRC-1:0] en;
    logic               emi;
  } ictl_s;

  function automatic logic [REG_W-1:0] ictl_image(input ictl_s s);
    return {{PAD_W{1'b0}}, s.flg, s.en, s.emi};
  endfunction

endpackage

// File: rtl/vpic_edge_sync.sv
module vpic_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic fall_o
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q, chain_d;
  logic              prev_q, prev_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = pin_i;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], pin_i};
    end
  endgenerate

  always_comb prev_d = chain_q[LAST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  assign fall_o = prev_q & ~chain_q[LAST];

endmodule

// File: rtl/vpic_arb.sv
module vpic_arb
  import vpic_pkg::*;
#(
  parameter int unsigned VEC_BASE = 4,
  parameter int unsigned VEC_STEP = 4
) (
  input  logic [NUM_SRC-1:0] req_i,
  output logic               hit_o,
  output logic [NUM_SRC-1:0] grant_o,
  output logic [VEC_W-1:0]   vec_o
);

  logic [NUM_SRC-1:0][VEC_W-1:0] vec_tab;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SRC; gi++) begin : g_vec
      localparam int unsigned ADDR = VEC_BASE + VEC_STEP * gi;
      assign vec_tab[gi] = VEC_W'(ADDR);
    end
  endgenerate

  always_comb begin
    grant_o = '0;
    hit_o   = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req_i[i] && !hit_o) begin
        grant_o[i] = 1'b1;
        hit_o      = 1'b1;
      end
    end
  end

  always_comb begin
    vec_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (grant_o[i]) vec_o = vec_o | vec_tab[i];
    end
  end

endmodule

// File: rtl/vpic_csr.sv
module vpic_csr
  import vpic_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [REG_W-1:0]   wdata_i,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic               take_i,
  input  logic [NUM_SRC-1:0] grant_i,
  input  ret_kind_e          ret_kind_i,
  output ictl_s              state_o,
  output logic [REG_W-1:0]   rdata_o
);

  ictl_s cur_q, nxt_d;
  logic  upd_en;

  always_comb begin
    nxt_d = cur_q;
    if (take_i) begin
      nxt_d.emi = 1'b0;
    end else begin
      case (ret_kind_i)
        RK_RETI: nxt_d.emi = 1'b1;
        RK_RET:  nxt_d.emi = cur_q.emi;
        default: if (we_i) nxt_d.emi = wdata_i[0];
      endcase
    end
    for (int i = 0; i < NUM_SRC; i++) begin
      if (we_i) nxt_d.en[i] = wdata_i[EN_LSB + i];
      if (set_i[i]) begin
        nxt_d.flg[i] = 1'b1;
      end else if (take_i && grant_i[i]) begin
        nxt_d.flg[i] = 1'b0;
      end else if (we_i) begin
        nxt_d.flg[i] = wdata_i[FLG_LSB + i];
      end
    end
  end

  assign upd_en = we_i | take_i | (|set_i) | (ret_kind_i == RK_RETI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
    end else if (upd_en) begin
      cur_q <= nxt_d;
    end
  end

  assign state_o = cur_q;
  assign rdata_o = ictl_image(cur_q);

endmodule

// File: rtl/vpic_ctrl.sv
module vpic_ctrl
  import vpic_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned VEC_BASE    = 4,
  parameter int unsigned VEC_STEP    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             ext_irq_ni,
  input  logic             tmr0_ovf_i,
  input  logic             tmr1_ovf_i,
  input  logic             stack_full_i,
  input  logic             ret_i,
  input  logic             reti_i,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             call_req_o,
  output logic [VEC_W-1:0] call_vec_o
);

  logic               ext_fall;
  logic [NUM_SRC-1:0] src_set;
  logic [NUM_SRC-1:0] eligible;
  logic [NUM_SRC-1:0] grant;
  logic               any_hit;
  logic [VEC_W-1:0]   arb_vec;
  logic               take;
  ictl_s              st;
  ret_kind_e          ret_kind;

  logic               call_q, call_d;
  logic [VEC_W-1:0]   vec_q, vec_d;

  vpic_edge_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (ext_irq_ni),
    .fall_o (ext_fall)
  );

  assign src_set = {tmr1_ovf_i, tmr0_ovf_i, ext_fall};

  always_comb begin
    if (reti_i)     ret_kind = RK_RETI;
    else if (ret_i) ret_kind = RK_RET;
    else            ret_kind = RK_NONE;
  end

  assign eligible = st.flg & st.en;

  vpic_arb #(.VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_arb (
    .req_i   (eligible),
    .hit_o   (any_hit),
    .grant_o (grant),
    .vec_o   (arb_vec)
  );

  assign take = tick_i & st.emi & ~stack_full_i & any_hit;

  vpic_csr u_csr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .wdata_i    (reg_wdata_i),
    .set_i      (src_set),
    .take_i     (take),
    .grant_i    (grant),
    .ret_kind_i (ret_kind),
    .state_o    (st),
    .rdata_o    (reg_rdata_o)
  );

  always_comb begin
    call_d = take;
    vec_d  = take ? arb_vec : vec_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      call_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      call_q <= call_d;
      if (take) vec_q <= vec_d;
    end
  end

  assign call_req_o = call_q;
  assign call_vec_o = vec_q;

endmodule

// File: rtl/vpic_ctrl_chk.sv
module vpic_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       stack_full_i,
  input logic       ret_i,
  input logic       reti_i,
  input logic       reg_we_i,
  input logic [7:0] reg_rdata_o,
  input logic       call_req_o,
  input logic [7:0] call_vec_o
);

  a_r2_top_bit_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[7] == 1'b0);

  a_r4_needs_master: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_req_o |-> $past(reg_rdata_o[0]));

  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_req_o |=> !call_req_o);

  a_r6_legal_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_req_o |-> (call_vec_o == 8'h04 || call_vec_o == 8'h08 || call_vec_o == 8'h0C));

  a_r7_master_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_req_o |-> !reg_rdata_o[0]);

  a_r8_reti_restores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reti_i |=> (reg_rdata_o[0] || call_req_o));

  a_r8_ret_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !reti_i && !reg_we_i) |=> (call_req_o || $stable(reg_rdata_o[0])));

  a_r9_only_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_req_o |-> $past(tick_i));

  a_r11_stack_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_req_o |-> !$past(stack_full_i));

endmodule

bind vpic_ctrl vpic_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_i),
  .stack_full_i (stack_full_i),
  .ret_i        (ret_i),
  .reti_i       (reti_i),
  .reg_we_i     (reg_we_i),
  .reg_rdata_o  (reg_rdata_o),
  .call_req_o   (call_req_o),
  .call_vec_o   (call_vec_o)
);

// File: tb/vpic_ctrl_tb_top.sv
module vpic_ctrl_tb_top;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b1;
  logic       tick_i = 1'b0;
  logic       ext_irq_ni = 1'b1;
  logic       tmr0_ovf_i = 1'b0;
  logic       tmr1_ovf_i = 1'b0;
  logic       stack_full_i = 1'b0;
  logic       ret_i = 1'b0;
  logic       reti_i = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [7:0] reg_wdata_i = 8'h00;
  logic [7:0] reg_rdata_o;
  logic       call_req_o;
  logic [7:0] call_vec_o;

  int n_chk = 0;
  int n_fail = 0;
  bit compare_on = 1'b0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  vpic_ctrl dut_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .ext_irq_ni   (ext_irq_ni),
    .tmr0_ovf_i   (tmr0_ovf_i),
    .tmr1_ovf_i   (tmr1_ovf_i),
    .stack_full_i (stack_full_i),
    .ret_i        (ret_i),
    .reti_i       (reti_i),
    .reg_we_i     (reg_we_i),
    .reg_wdata_i  (reg_wdata_i),
    .reg_rdata_o  (reg_rdata_o),
    .call_req_o   (call_req_o),
    .call_vec_o   (call_vec_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model of the register image and call output
  bit       m_emi;
  bit [2:0] m_en;
  bit [2:0] m_flg;
  bit       m_call;
  int       m_vec;
  bit       pin_hist[$];

  function automatic int m_image();
    return {1'b0, m_flg, m_en, m_emi};
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_emi = 0; m_en = 0; m_flg = 0; m_call = 0; m_vec = 0;
      pin_hist = '{1'b1, 1'b1, 1'b1};
    end else begin
      bit [2:0] set;
      bit       tk;
      int       sel;
      set[0] = (pin_hist[2] == 1'b1) && (pin_hist[1] == 1'b0);
      set[1] = tmr0_ovf_i;
      set[2] = tmr1_ovf_i;
      sel = -1;
      for (int i = 2; i >= 0; i--) if (m_flg[i] && m_en[i]) sel = i;
      tk = tick_i && m_emi && !stack_full_i && (sel >= 0);
      for (int i = 0; i < 3; i++) begin
        if (set[i]) m_flg[i] = 1'b1;
        else if (tk && sel == i) m_flg[i] = 1'b0;
        else if (reg_we_i) m_flg[i] = reg_wdata_i[4 + i];
        if (reg_we_i) m_en[i] = reg_wdata_i[1 + i];
      end
      if (tk) m_emi = 1'b0;
      else if (reti_i) m_emi = 1'b1;
      else if (ret_i) m_emi = m_emi;
      else if (reg_we_i) m_emi = reg_wdata_i[0];
      m_call = tk;
      if (tk) m_vec = 4 + 4 * sel;
      pin_hist.push_front(ext_irq_ni);
      void'(pin_hist.pop_back());
    end
  end

  always @(negedge clk_i) begin
    if (compare_on && rst_ni) begin
      check("R10 register model", 32'(reg_rdata_o), 32'(m_image()));
      check("R5 call model", 32'(call_req_o), 32'(m_call));
      check("R6 vector model", 32'(call_vec_o), 32'(m_vec));
    end
  end

  task automatic cyc();
    @(posedge clk_i);
    #2;
  endtask

  task automatic wr(input logic [7:0] d);
    reg_we_i = 1'b1;
    reg_wdata_i = d;
    cyc();
    reg_we_i = 1'b0;
  endtask

  task automatic tick_cyc();
    tick_i = 1'b1;
    cyc();
    tick_i = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) cyc();
    check("R1 reset register", 32'(reg_rdata_o), 32'h00);
    check("R1 reset call", 32'(call_req_o), 32'h0);
    rst_ni = 1'b1;
    compare_on = 1'b1;
    cyc();
    check("R1 first cycle register", 32'(reg_rdata_o), 32'h00);

    // R2 layout and write
    wr(8'hFF);
    check("R2 write all ones", 32'(reg_rdata_o), 32'h7F);
    wr(8'h5A);
    check("R2 mixed pattern", 32'(reg_rdata_o), 32'h5A);
    wr(8'h00);
    check("R10 software clear", 32'(reg_rdata_o), 32'h00);

    // R3 timer pulse
    tmr0_ovf_i = 1'b1; cyc(); tmr0_ovf_i = 1'b0;
    check("R3 timer0 flag", 32'(reg_rdata_o), 32'h20);
    tmr1_ovf_i = 1'b1; cyc(); tmr1_ovf_i = 1'b0;
    check("R3 timer1 flag", 32'(reg_rdata_o), 32'h60);
    wr(8'h00);

    // R3 external falling edge latency
    ext_irq_ni = 1'b0;
    cyc(); cyc();
    check("R3 ext not yet", 32'(reg_rdata_o), 32'h00);
    cyc();
    check("R3 ext third edge", 32'(reg_rdata_o), 32'h10);
    wr(8'h00);
    ext_irq_ni = 1'b1;
    repeat (5) cyc();
    check("R3 rising edge ignored", 32'(reg_rdata_o), 32'h00);

    // R5 R6 R7 priority and vectors
    wr(8'h7F);
    tick_cyc();
    check("R6 call pulse", 32'(call_req_o), 32'h1);
    check("R5 ext first", 32'(call_vec_o), 32'h04);
    check("R7 flag and master cleared", 32'(reg_rdata_o), 32'h6E);
    cyc();
    check("R6 pulse one cycle", 32'(call_req_o), 32'h0);
    reti_i = 1'b1; cyc(); reti_i = 1'b0;
    check("R8 reti restores", 32'(reg_rdata_o), 32'h6F);
    tick_cyc();
    check("R5 timer0 second", 32'(call_vec_o), 32'h08);
    check("R7 timer0 clear", 32'(reg_rdata_o), 32'h4E);
    reti_i = 1'b1; cyc(); reti_i = 1'b0;
    tick_cyc();
    check("R5 timer1 last", 32'(call_vec_o), 32'h0C);
    check("R7 timer1 clear", 32'(reg_rdata_o), 32'h0E);
    ret_i = 1'b1; cyc(); ret_i = 1'b0;
    check("R8 ret leaves master", 32'(reg_rdata_o), 32'h0E);

    // R10 masked flag kept
    tmr1_ovf_i = 1'b1; cyc(); tmr1_ovf_i = 1'b0;
    tick_cyc();
    check("R10 masked no call", 32'(call_req_o), 32'h0);
    check("R10 masked flag kept", 32'(reg_rdata_o), 32'h4E);

    // R4 source enable off
    wr(8'h41);
    tick_cyc();
    check("R4 disabled source", 32'(call_req_o), 32'h0);
    check("R4 state kept", 32'(reg_rdata_o), 32'h41);

    // R11 stack full
    wr(8'h49);
    stack_full_i = 1'b1;
    tick_cyc();
    check("R11 blocked when full", 32'(call_req_o), 32'h0);
    check("R11 flag kept", 32'(reg_rdata_o), 32'h49);
    stack_full_i = 1'b0;
    tick_cyc();
    check("R11 served after room", 32'(call_vec_o), 32'h0C);
    check("R11 cleared after serve", 32'(reg_rdata_o), 32'h08);

    // R9 wait for tick
    wr(8'h05);
    tmr0_ovf_i = 1'b1; cyc(); tmr0_ovf_i = 1'b0;
    check("R9 latched", 32'(reg_rdata_o), 32'h25);
    repeat (3) cyc();
    check("R9 no call without tick", 32'(call_req_o), 32'h0);
    tick_cyc();
    check("R9 served on tick", 32'(call_req_o), 32'h1);
    check("R9 vector", 32'(call_vec_o), 32'h08);

    // R10 hardware set beats write
    reg_we_i = 1'b1; reg_wdata_i = 8'h00; tmr0_ovf_i = 1'b1;
    cyc();
    reg_we_i = 1'b0; tmr0_ovf_i = 1'b0;
    check("R10 set wins over write", 32'(reg_rdata_o), 32'h20);

    // R7 take beats coincident reti
    wr(8'h25);
    tick_i = 1'b1; reti_i = 1'b1; cyc(); tick_i = 1'b0; reti_i = 1'b0;
    check("R7 take over reti", 32'(reg_rdata_o), 32'h04);

    // mixed stimulus against the model
    for (int n = 0; n < 3000; n++) begin
      tick_i       = ($urandom_range(3) == 0);
      tmr0_ovf_i   = ($urandom_range(15) == 0);
      tmr1_ovf_i   = ($urandom_range(15) == 0);
      stack_full_i = ($urandom_range(5) == 0);
      ret_i        = ($urandom_range(9) == 0);
      reti_i       = ($urandom_range(7) == 0);
      reg_we_i     = ($urandom_range(19) == 0);
      reg_wdata_i  = 8'($urandom);
      if ($urandom_range(7) == 0) ext_irq_ni = ~ext_irq_ni;
      cyc();
    end
    tick_i = 0; tmr0_ovf_i = 0; tmr1_ovf_i = 0; stack_full_i = 0;
    ret_i = 0; reti_i = 0; reg_we_i = 0;
    repeat (4) cyc();
    summary();
    $finish;
  end

endmodule